// File: doc/BRIEF.md
# UART Receive FIFO Status Controller

This block sits behind a UART deserializer and owns everything between a finished received frame and the CPU. Each byte the deserializer hands over is pushed into a 16-entry FIFO together with its error indications. A bank of sticky status flags records data arrival, receive errors, breaks, FIFO threshold crossings and overruns. A pulse output signals the CPU whenever the threshold flag rises.

Software reaches the block through a small register port. It can pop bytes, read the fill count, read the flags and the live receive line, and program the receive enable and the threshold. Every flag uses a guarded clear: software must first read the flag as 1, and only a later write of 0 to that bit clears it. A clear therefore never discards an event that software has not yet seen.

Register map (cpu_addr): 0 = data (a read pops one byte); 1 = status, with bit0 threshold reached, bit1 data arrived, bit2 receive error, bit3 break; 2 = control, with bit0 receive enable and bits[2:1] threshold select; 3 = fill count; 4 = line, with bit0 overrun and bit1 live receive line level. Bits that are not listed read as 0.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: After reset the status, control and fill-count registers read 0. The line register shows only the live line level in bit1. rx_irq is low.
- R2: With receive enable (control bit0) set, each rx_valid byte is stored. Reads of address 0 return the bytes in arrival order, and each read lowers the fill count at address 3 by one.
- R3: While receive enable is 0, rx_valid bytes are ignored: the fill count and the status flags stay unchanged.
- R4: Status bit0 becomes 1 once the fill count is at or above the threshold. Threshold select 00, 01, 10 and 11 gives a threshold of 1, 4, 8 and 14 bytes.
- R5: rx_irq is a one-cycle pulse that follows each 0-to-1 change of status bit0.
- R6: A flag clears only when a 0 is written to its bit after a read of its register has returned that bit as 1. A 0 write with no such earlier read leaves the flag set. Writing 1 never changes a flag. Each flag is cleared on its own.
- R7: If status bit0 is cleared while the fill count is still at or above the threshold, it sets again on the next clock and produces a new rx_irq pulse.
- R8: Every stored byte sets status bit1. A stored byte with a framing or parity error sets bit2. A stored byte with a framing error and all data bits 0 also sets bit3.
- R9: A byte that arrives while 16 bytes are held is dropped. The count stays 16 and line bit0 (overrun) is set.
- R10: A data read while the FIFO is empty returns the last byte popped and leaves the count at 0.
- R11: Line register bit1 follows the rx_line input, so software can tell a break from an ordinary framing error.
- R12: The fill count never exceeds the FIFO depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Deserializer presents a finished byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Stop bit of this byte was invalid |
| rx_parity_err | input | 1 | Parity of this byte was wrong |
| rx_line | input | 1 | Live level of the serial receive line |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the same cycle as the access |
| rx_irq | output | 1 | Threshold interrupt pulse |

## Verification
A corrupted read or write pointer shows up on the next data read as a byte out of order or a repeated byte. A wrong fill count shows up on the next read of the count register, and also as a threshold flag that rises one byte early or late. A fault in the read-before-clear bookkeeping shows up on the status read right after a clear write: a flag is either still present or already gone. A missing re-assertion of the threshold flag shows up within two cycles as an absent rx_irq pulse.

// File: rtl/rxf_pkg.sv
// Package: shared register addresses, flag indices and threshold decode
// for the UART receive FIFO status controller.
package rxf_pkg;

    localparam int ADDR_W = 3;

    // Register addresses seen on cpu_addr
    localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_LINE  = 3'd4;

    // Flag indices. Indices 0..3 match their status-register bit positions.
    localparam int FLAG_THR   = 0;
    localparam int FLAG_ARR   = 1;
    localparam int FLAG_ERR   = 2;
    localparam int FLAG_BRK   = 3;
    localparam int FLAG_OVR   = 4;
    localparam int NUM_FLAGS  = 5;

    // Threshold in bytes for a 2-bit select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Module: rxf_store
// Byte FIFO with circular pointers and a fill counter.
// Assumes: the caller never pushes when full and never pops when empty.
// head shows the oldest entry without removing it.
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming byte into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Move the pointers and the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Derive the head byte and the occupancy flags
    always_comb begin
        head  = mem[rd_ptr];
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/rxf_flag.sv
// Module: rxf_flag
// One sticky status flag with a guarded clear. A read of the flag's
// register while the flag is 1 arms the flag. A later write with the
// flag's bit at 0 clears it, but only when it is armed. The clear takes
// priority over a set in the same cycle.
// Assumes: rd_i and wr_i are never high together.
module rxf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    logic armed;

    // Update the flag and its armed state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else if (wr_i && !wbit_i && armed) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (set_i)          flag_o <= 1'b1;
            if (rd_i && flag_o) armed  <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
// Module: uart_rx_fifo_ctrl (top)
// Receive-side FIFO, status flags and threshold interrupt of a UART.
// Takes finished bytes and their error bits from a deserializer and
// serves a one-cycle register port.
// Assumes: cpu_sel is high for exactly one cycle per access, and
// cpu_rdata is sampled in that same cycle.
module uart_rx_fifo_ctrl
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int REG_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              rx_line,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              rx_irq
);

    logic                 rx_en;
    logic [1:0]           trig_sel;
    logic [CNT_W-1:0]     trig_lvl;
    logic [CNT_W-1:0]     fifo_count;
    logic [DATA_W-1:0]    fifo_head;
    logic [DATA_W-1:0]    last_q;
    logic                 fifo_full;
    logic                 fifo_empty;
    logic                 accept;
    logic                 push;
    logic                 pop;
    logic                 overrun;
    logic                 rd_strobe;
    logic                 wr_strobe;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 thr_q;

    // Qualify the deserializer input and the CPU accesses
    always_comb begin
        rd_strobe = cpu_sel && !cpu_wr;
        wr_strobe = cpu_sel && cpu_wr;
        accept    = rx_valid && rx_en;
        push      = accept && !fifo_full;
        overrun   = accept && fifo_full;
        pop       = rd_strobe && (cpu_addr == ADDR_DATA) && !fifo_empty;
    end

    // Decode the threshold select, clamped to the FIFO depth
    always_comb begin
        int unsigned raw;
        raw      = trig_level(trig_sel);
        trig_lvl = (raw > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(raw);
    end

    rxf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .wdata  (rx_data),
        .pop    (pop),
        .head   (fifo_head),
        .count  (fifo_count),
        .full   (fifo_full),
        .empty  (fifo_empty)
    );

    // Hold the control register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en    <= 1'b0;
            trig_sel <= 2'd0;
        end else if (wr_strobe && cpu_addr == ADDR_CTRL) begin
            rx_en    <= cpu_wdata[0];
            trig_sel <= cpu_wdata[2:1];
        end
    end

    // Keep the most recently popped byte for reads of an empty FIFO
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= '0;
        else if (pop) last_q <= fifo_head;
    end

    // Build the set condition of each flag
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_THR] = (fifo_count >= trig_lvl);
        flag_set[FLAG_ARR] = push;
        flag_set[FLAG_ERR] = push && (rx_frame_err || rx_parity_err);
        flag_set[FLAG_BRK] = push && rx_frame_err && (rx_data == '0);
        flag_set[FLAG_OVR] = overrun;
    end

    // One guarded-clear flag cell per flag, each wired to its home register
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam logic [ADDR_W-1:0] HOME   = (g == FLAG_OVR) ? ADDR_LINE : ADDR_STAT;
        localparam int                BITPOS = (g == FLAG_OVR) ? 0 : g;
        rxf_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .rd_i   (rd_strobe && cpu_addr == HOME),
            .wr_i   (wr_strobe && cpu_addr == HOME),
            .wbit_i (cpu_wdata[BITPOS]),
            .flag_o (flag_q[g])
        );
    end

    // Delay the threshold flag so its rising edge can be detected
    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= 1'b0;
        else        thr_q <= flag_q[FLAG_THR];
    end

    // Raise the interrupt for one cycle on each rising threshold flag
    always_comb begin
        rx_irq = flag_q[FLAG_THR] && !thr_q;
    end

    // Select the read data for the addressed register
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            ADDR_DATA:  cpu_rdata[DATA_W-1:0] = fifo_empty ? last_q : fifo_head;
            ADDR_STAT:  cpu_rdata[3:0]        = flag_q[FLAG_BRK:FLAG_THR];
            ADDR_CTRL:  cpu_rdata[2:0]        = {trig_sel, rx_en};
            ADDR_COUNT: cpu_rdata[CNT_W-1:0]  = fifo_count;
            ADDR_LINE:  cpu_rdata[1:0]        = {rx_line, flag_q[FLAG_OVR]};
            default:    cpu_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
// Module: rxf_checker
// Temporal properties of uart_rx_fifo_ctrl. It is attached to the top
// module through the bind statement at the end of this file.
// Assumes: it is clocked and reset together with the design.
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int REG_W = 8,
    parameter int CNT_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 rx_en,
    input logic                 fifo_full,
    input logic                 pop,
    input logic [CNT_W-1:0]     fifo_count,
    input logic [CNT_W-1:0]     trig_lvl,
    input logic [NUM_FLAGS-1:0] flag_q,
    input logic                 rx_irq,
    input logic                 cpu_sel,
    input logic                 cpu_wr,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic [REG_W-1:0]     cpu_wdata
);

    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R3
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_en && !pop) |=> (fifo_count == $past(fifo_count)));

    // R9
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && fifo_full && !pop) |=> (fifo_count == CNT_W'(DEPTH)));

    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && fifo_full && !(cpu_sel && cpu_wr)) |=> flag_q[FLAG_OVR]);

    // R6
    thr_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[FLAG_THR]) |->
            $past(cpu_sel && cpu_wr && cpu_addr == ADDR_STAT && !cpu_wdata[0]));

    // R4
    thr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[FLAG_THR] && fifo_count >= trig_lvl) |=> flag_q[FLAG_THR]);

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

endmodule

bind uart_rx_fifo_ctrl rxf_checker #(
    .DEPTH (DEPTH),
    .REG_W (REG_W),
    .CNT_W (CNT_W)
) i_rxf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_en      (rx_en),
    .fifo_full  (fifo_full),
    .pop        (pop),
    .fifo_count (fifo_count),
    .trig_lvl   (trig_lvl),
    .flag_q     (flag_q),
    .rx_irq     (rx_irq),
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata)
);

// File: tb/test_uart_rx_fifo_ctrl.sv
// Bench for uart_rx_fifo_ctrl: a vector table for per-byte flags, then
// directed tests for reset, guarded clears, thresholds, overrun and empty reads.
module test_uart_rx_fifo_ctrl;
    import rxf_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_frame_err;
    logic       rx_parity_err;
    logic       rx_line;
    logic       cpu_sel;
    logic       cpu_wr;
    logic [2:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       rx_irq;

    int n_cmp   = 0;
    int n_bad   = 0;
    int irq_cnt = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo_ctrl i_uart_rx_fifo_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err),
        .rx_line       (rx_line),
        .cpu_sel       (cpu_sel),
        .cpu_wr        (cpu_wr),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .rx_irq        (rx_irq)
    );

    // Vector fields: [13:6] byte, [5] framing error, [4] parity error,
    // [3:0] expected status {break, error, arrived, threshold} at threshold 1
    localparam logic [13:0] VEC [6] = '{
        {8'h55, 1'b0, 1'b0, 4'b0011},
        {8'h00, 1'b1, 1'b0, 4'b1111},
        {8'hA3, 1'b1, 1'b0, 4'b0111},
        {8'h3C, 1'b0, 1'b1, 4'b0111},
        {8'h00, 1'b0, 1'b1, 4'b0111},
        {8'h00, 1'b0, 1'b0, 4'b0011}
    };

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        cpu_read(a, d);
        check(req, d, exp);
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic fe, input logic pe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_frame_err = fe; rx_parity_err = pe;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_frame_err = 1'b0;
        rx_parity_err = 1'b0; rx_line = 1'b1; cpu_sel = 1'b0; cpu_wr = 1'b0;
        cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check(ADDR_STAT,  8'h00, "R1 status");
        rd_check(ADDR_CTRL,  8'h00, "R1 control");
        rd_check(ADDR_COUNT, 8'h00, "R1 count");
        rd_check(ADDR_LINE,  8'h02, "R1 line");
        check("R1 irq", 8'(irq_cnt), 8'd0);

        // R3: a byte offered while disabled is ignored
        push(8'h11, 1'b1, 1'b0);
        rd_check(ADDR_COUNT, 8'h00, "R3 count");
        rd_check(ADDR_STAT,  8'h00, "R3 status");

        // R8/R2/R6: table of bytes at threshold 1
        cpu_write(ADDR_CTRL, 8'h01);
        for (int i = 0; i < 6; i++) begin
            push(VEC[i][13:6], VEC[i][5], VEC[i][4]);
            rd_check(ADDR_STAT, {4'b0, VEC[i][3:0]}, "R8 status per byte");
            rd_check(ADDR_DATA, VEC[i][13:6], "R2 popped byte");
            cpu_write(ADDR_STAT, 8'h00);
            rd_check(ADDR_STAT, 8'h00, "R6 cleared after read");
        end
        check("R5 irq per rise", 8'(irq_cnt), 8'd6);

        // R6: a 0 write without a prior read, writes of 1, per-bit clears
        push(8'h22, 1'b0, 1'b1);
        cpu_write(ADDR_STAT, 8'h00);
        rd_check(ADDR_STAT, 8'h07, "R6 unarmed write");
        cpu_write(ADDR_STAT, 8'h0F);
        rd_check(ADDR_STAT, 8'h07, "R6 write of ones");
        cpu_write(ADDR_STAT, 8'h01);
        rd_check(ADDR_STAT, 8'h01, "R6 per-bit clear");
        rd_check(ADDR_DATA, 8'h22, "R2 popped byte");
        cpu_write(ADDR_STAT, 8'h00);
        rd_check(ADDR_STAT, 8'h00, "R6 final clear");

        // R4/R5/R7: threshold 4
        cpu_write(ADDR_CTRL, 8'h03);
        for (int k = 0; k < 3; k++) push(8'h80 + 8'(k), 1'b0, 1'b0);
        rd_check(ADDR_STAT, 8'h02, "R4 below 4");
        push(8'h83, 1'b0, 1'b0);
        rd_check(ADDR_STAT, 8'h03, "R4 at 4");
        check("R5 irq at 4", 8'(irq_cnt), 8'd8);
        cpu_write(ADDR_STAT, 8'h02);
        repeat (3) @(negedge clk);
        check("R7 irq again", 8'(irq_cnt), 8'd9);
        rd_check(ADDR_STAT, 8'h03, "R7 threshold set again");

        // R4: threshold 14
        cpu_write(ADDR_CTRL, 8'h07);
        cpu_write(ADDR_STAT, 8'h00);
        rd_check(ADDR_STAT, 8'h00, "R4 count 4 below 14");
        for (int k = 4; k < 13; k++) push(8'h80 + 8'(k), 1'b0, 1'b0);
        rd_check(ADDR_COUNT, 8'd13, "R2 count 13");
        rd_check(ADDR_STAT, 8'h02, "R4 count 13");
        push(8'h8D, 1'b0, 1'b0);
        rd_check(ADDR_STAT, 8'h03, "R4 count 14");
        check("R5 irq at 14", 8'(irq_cnt), 8'd10);

        // R9: fill and overrun
        push(8'h8E, 1'b0, 1'b0);
        push(8'h8F, 1'b0, 1'b0);
        push(8'hEE, 1'b0, 1'b0);
        rd_check(ADDR_COUNT, 8'd16, "R9 count held");
        rd_check(ADDR_LINE, 8'h03, "R9 overrun flag");
        cpu_write(ADDR_LINE, 8'h00);
        rd_check(ADDR_LINE, 8'h02, "R6 overrun cleared");

        // R2: drain in order, the dropped byte absent
        for (int k = 0; k < 16; k++) rd_check(ADDR_DATA, 8'h80 + 8'(k), "R2 order");
        rd_check(ADDR_COUNT, 8'd0, "R2 drained");

        // R10: read of an empty FIFO
        rd_check(ADDR_DATA, 8'h8F, "R10 last value");
        rd_check(ADDR_COUNT, 8'd0, "R10 count unchanged");

        // R11: live line level
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rd_check(ADDR_LINE, 8'h00, "R11 line low");

        cpu_read(ADDR_CTRL, d);
        check("R4 control readback", d, 8'h07);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule